// File: doc/BRIEF.md
# Drawing Command Register Window

This block is the CPU-facing front end of a drawing accelerator. It answers a 16-byte window of an 8-bit processor bus. Software first stores the parameters of an operation (two coordinate pairs and a colour) in the low locations of the window. It then writes a command code to the command location. That write raises a pending flag, which is presented to the drawing engine as a start request together with the latched command and parameters.

The engine acknowledges with a one-cycle accept pulse when it takes the work, and that pulse alone clears the pending flag. From accept until the engine's done pulse the block counts the engine as running. A read of the command location returns a status byte whose top bit shows busy, meaning pending or running. Software polls that bit before it issues the next command. Bus reads never touch the handshake, so polling cannot restart an operation. Command and parameter writes made while busy are dropped.

Top module: `draw_cmd_port`

## Requirements
- R1: The block responds only when bus_addr[15:4] equals BASE_ADDR[15:4] (default 16'h9100). Any other address gives bus_rdata 8'h00 and leaves all state unchanged.
- R2: Window offsets 0 to 4 are parameter registers. A read returns the value last written, and register i appears on eng_param[8*i+7:8*i].
- R3: A read of offset 5 returns 8'h80 when busy and 8'h00 when not busy. Busy means a command is pending (eng_start high) or the engine is running, which lasts from an accepted start until eng_done.
- R4: A write to offset 5 while not busy latches the byte on eng_cmd and drives eng_start high from the next cycle.
- R5: An eng_accept sampled while eng_start is high drops eng_start on the next cycle and marks the engine running.
- R6: Bus reads at any offset, repeated or not, never change eng_start. eng_start rises only after a write to offset 5.
- R7: Offsets 6 to 15 read as 8'h00, and writes to them are ignored.
- R8: While busy, writes to offset 5 are ignored (eng_cmd unchanged, no new start) and writes to offsets 0 to 4 are ignored.
- R9: A synchronous active-high rst clears the parameters, the command, the pending flag and the running state.
- R10: eng_accept while eng_start is low is ignored. eng_done ends the running state, and eng_done while not running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU byte address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd, zero otherwise |
| eng_start | output | 1 | Pending command request to the engine |
| eng_cmd | output | 8 | Latched command code |
| eng_param | output | 40 | Parameter registers, register i in byte i |
| eng_accept | input | 1 | Engine takes the pending command (one-cycle pulse) |
| eng_done | input | 1 | Engine finished the operation (one-cycle pulse) |

## Verification
A pending flag stuck high shows at the ports as eng_start staying high through status polls after accept. A flag that clears on the wrong event shows as eng_start falling without an accept. Either is visible one cycle after the offending edge. A broken running state shows up at the next status read as the wrong busy bit, or as a command or parameter write that changes eng_cmd or eng_param when it should have been dropped. Decode faults show at once as nonzero read data outside the window or in the unused offsets.

// File: rtl/draw_cmd_pkg.sv
package draw_cmd_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              valid;
        logic              running;
        logic [DATA_W-1:0] cmd;
    } hs_state_t;
endpackage

// File: rtl/draw_cmd_decode.sv
module draw_cmd_decode #(
    parameter int              ADDR_W    = 16,
    parameter int              WIN_W     = 4,
    parameter int              NUM_PARAM = 5,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h9100
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WIN_W-1:0]  offset,
    output logic              is_param,
    output logic              is_cmd
);
    localparam logic [WIN_W-1:0] CMD_OFS = WIN_W'(NUM_PARAM);

    always_comb begin
        hit      = (addr[ADDR_W-1:WIN_W] == BASE_ADDR[ADDR_W-1:WIN_W]);
        offset   = addr[WIN_W-1:0];
        is_param = hit && (offset < CMD_OFS);
        is_cmd   = hit && (offset == CMD_OFS);
    end
endmodule

// File: rtl/draw_cmd_regfile.sv
module draw_cmd_regfile #(
    parameter int NUM_PARAM = 5,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_PARAM-1:0][DATA_W-1:0] regs
);
    logic [NUM_PARAM-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_PARAM; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/draw_cmd_handshake.sv
module draw_cmd_handshake
    import draw_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              eng_accept,
    input  logic              eng_done,
    output logic              valid,
    output logic              busy,
    output logic [DATA_W-1:0] cmd
);
    hs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new command is taken only while nothing is pending or running
        if (cmd_wr && !(st_q.valid || st_q.running)) begin
            st_d.cmd   = cmd_data;
            st_d.valid = 1'b1;
        end
        if (eng_done) begin
            st_d.running = 1'b0;
        end
        // only the engine's accept retires the pending flag
        if (eng_accept && st_q.valid) begin
            st_d.valid   = 1'b0;
            st_d.running = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign busy  = st_q.valid | st_q.running;
    assign cmd   = st_q.cmd;
endmodule

// File: rtl/draw_cmd_port.sv
module draw_cmd_port
    import draw_cmd_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              WIN_W     = 4,
    parameter int              NUM_PARAM = 5,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h9100
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          eng_start,
    output logic [DATA_W-1:0]             eng_cmd,
    output logic [NUM_PARAM*DATA_W-1:0]   eng_param,
    input  logic                          eng_accept,
    input  logic                          eng_done
);
    logic                             hit, is_param, is_cmd, busy;
    logic [WIN_W-1:0]                 offset;
    logic [NUM_PARAM-1:0][DATA_W-1:0] regs;

    draw_cmd_decode #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_PARAM(NUM_PARAM), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(bus_addr), .hit(hit), .offset(offset), .is_param(is_param), .is_cmd(is_cmd)
    );

    draw_cmd_regfile #(
        .NUM_PARAM(NUM_PARAM), .DATA_W(DATA_W), .IDX_W(WIN_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(bus_wr && is_param && !busy),
        .wr_idx(offset), .wr_data(bus_wdata), .regs(regs)
    );

    draw_cmd_handshake u_hs (
        .clk(clk), .rst(rst),
        .cmd_wr(bus_wr && is_cmd), .cmd_data(bus_wdata),
        .eng_accept(eng_accept), .eng_done(eng_done),
        .valid(eng_start), .busy(busy), .cmd(eng_cmd)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) begin
            if (is_cmd) begin
                bus_rdata = {busy, {(DATA_W-1){1'b0}}};
            end
            for (int i = 0; i < NUM_PARAM; i++) begin
                if (offset == WIN_W'(i)) bus_rdata = regs[i];
            end
        end
    end

    assign eng_param = regs;
endmodule

// File: rtl/draw_cmd_port_chk.sv
module draw_cmd_port_chk #(
    parameter int              ADDR_W    = 16,
    parameter int              WIN_W     = 4,
    parameter int              NUM_PARAM = 5,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h9100
) (
    input logic                        clk,
    input logic                        rst,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [7:0]                  bus_rdata,
    input logic                        eng_start,
    input logic [NUM_PARAM*8-1:0]      eng_param,
    input logic                        eng_accept
);
    logic             c_hit, c_cmd, c_unused;
    assign c_hit    = (bus_addr[ADDR_W-1:WIN_W] == BASE_ADDR[ADDR_W-1:WIN_W]);
    assign c_cmd    = c_hit && (bus_addr[WIN_W-1:0] == WIN_W'(NUM_PARAM));
    assign c_unused = c_hit && (bus_addr[WIN_W-1:0] > WIN_W'(NUM_PARAM));

    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !c_hit |-> bus_rdata == 8'h00); // R1
    AST_PENDING_BUSY: assert property (@(posedge clk) disable iff (rst)
        (eng_start && bus_rd && c_cmd) |-> bus_rdata == 8'h80); // R3
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_start) |-> $past(bus_wr && c_cmd)); // R4
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (eng_start && eng_accept) |=> !eng_start); // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!eng_start && !(bus_wr && c_cmd)) |=> !eng_start); // R6
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && c_unused) |-> bus_rdata == 8'h00); // R7
    AST_PARAM_FROZEN: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> $stable(eng_param)); // R8
endmodule

bind draw_cmd_port draw_cmd_port_chk #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_PARAM(NUM_PARAM), .BASE_ADDR(BASE_ADDR)
) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_param(eng_param),
    .eng_accept(eng_accept)
);

// File: tb/draw_cmd_port_tb_top.sv
`timescale 1ns/1ps
module draw_cmd_port_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd, eng_accept, eng_done;
    logic [7:0]  bus_wdata, bus_rdata, eng_cmd;
    logic        eng_start;
    logic [39:0] eng_param;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0] m_par [5];
    logic [7:0] m_cmd;
    bit         m_valid, m_run;

    always #10 clk = ~clk;

    draw_cmd_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_cmd(eng_cmd), .eng_param(eng_param), .eng_accept(eng_accept),
        .eng_done(eng_done)
    );

    function automatic bit in_win(input logic [15:0] a);
        return a[15:4] == 12'h910;
    endfunction

    task automatic cyc(input bit r, input bit wr, input bit rd, input logic [15:0] a,
                       input logic [7:0] d, input bit acc, input bit dn, input string tag);
        logic [7:0]  e_rd;
        logic [39:0] e_par;
        bit          busy;
        int          off;
        rst = r; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        eng_accept = acc; eng_done = dn;
        @(negedge clk);
        busy = m_valid || m_run;
        off  = int'(a[3:0]);
        e_rd = 8'h00;
        if (rd && in_win(a)) begin
            if (off < 5)       e_rd = m_par[off];
            else if (off == 5) e_rd = busy ? 8'h80 : 8'h00;
        end
        for (int i = 0; i < 5; i++) e_par[8*i +: 8] = m_par[i];
        checks++;
        if (bus_rdata !== e_rd || eng_start !== m_valid || eng_cmd !== m_cmd || eng_param !== e_par) begin
            failures++;
            $display("FAIL %s rdata=%h/%h start=%b/%b cmd=%h/%h param=%h/%h", tag,
                     bus_rdata, e_rd, eng_start, m_valid, eng_cmd, m_cmd, eng_param, e_par);
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 5; i++) m_par[i] = 8'h00;
            m_cmd = 8'h00; m_valid = 0; m_run = 0;
        end else begin
            bit old_valid = m_valid;
            if (wr && in_win(a) && !busy) begin
                if (off < 5) m_par[off] = d;
                else if (off == 5) begin m_cmd = d; m_valid = 1; end
            end
            if (dn) m_run = 0;
            if (acc && old_valid) begin m_valid = 0; m_run = 1; end
        end
        #1;
    endtask

    task automatic wrb(input logic [15:0] a, input logic [7:0] d, input string tag);
        cyc(0, 1, 0, a, d, 0, 0, tag);
    endtask
    task automatic rdb(input logic [15:0] a, input string tag);
        cyc(0, 0, 1, a, 8'h00, 0, 0, tag);
    endtask

    task automatic run_op(input logic [7:0] cmd, input int wait_acc, input int run_time);
        for (int i = 0; i < 5; i++) wrb(16'h9100 + 16'(i), cmd + 8'(i * 3), "R2");
        wrb(16'h9105, cmd, "R4");
        for (int i = 0; i < wait_acc; i++) rdb(16'h9105, "R6");
        cyc(0, 0, 1, 16'h9105, 8'h00, 1, 0, "R5");
        for (int i = 0; i < run_time; i++) rdb(16'h9105, "R6");
        cyc(0, 0, 1, 16'h9105, 8'h00, 0, 1, "R10");
        rdb(16'h9105, "R3");
    endtask

    initial begin
        for (int i = 0; i < 5; i++) m_par[i] = 8'h00;
        m_cmd = 8'h00; m_valid = 0; m_run = 0;
        rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        eng_accept = 0; eng_done = 0;
        @(posedge clk); #1;
        repeat (2) cyc(1, 0, 0, 16'h0, 8'h00, 0, 0, "R9");
        cyc(0, 0, 0, 16'h0, 8'h00, 0, 0, "R9");
        rdb(16'h9105, "R3");
        // parameters
        for (int i = 0; i < 5; i++) wrb(16'h9100 + 16'(i), 8'h11 * 8'(i + 1), "R2");
        for (int i = 0; i < 5; i++) rdb(16'h9100 + 16'(i), "R2");
        // unused offsets
        for (int i = 6; i < 16; i++) wrb(16'h9100 + 16'(i), 8'hA5, "R7");
        for (int i = 6; i < 16; i++) rdb(16'h9100 + 16'(i), "R7");
        // outside the window
        wrb(16'h9000, 8'h5A, "R1");
        wrb(16'h9110, 8'h5A, "R1");
        wrb(16'h9115, 8'h3C, "R1");
        rdb(16'h9015, "R1");
        rdb(16'h9110, "R1");
        rdb(16'h9100, "R1");
        // command, then polling with no accept
        wrb(16'h9105, 8'h21, "R4");
        for (int i = 0; i < 6; i++) rdb(16'h9105, "R6");
        for (int i = 0; i < 5; i++) rdb(16'h9100 + 16'(i), "R6");
        wrb(16'h9105, 8'h44, "R8");
        wrb(16'h9102, 8'hEE, "R8");
        cyc(0, 0, 1, 16'h9105, 8'h00, 1, 0, "R5");
        for (int i = 0; i < 10; i++) rdb(16'h9105, "R6");
        wrb(16'h9105, 8'h33, "R8");
        wrb(16'h9100, 8'h77, "R8");
        cyc(0, 0, 1, 16'h9105, 8'h00, 1, 0, "R10");
        // command write in the cycle of done is still dropped
        cyc(0, 1, 0, 16'h9105, 8'h66, 0, 1, "R8");
        rdb(16'h9105, "R3");
        cyc(0, 0, 0, 16'h0, 8'h00, 0, 1, "R10");
        cyc(0, 0, 0, 16'h0, 8'h00, 1, 0, "R10");
        rdb(16'h9105, "R10");
        // stub engine with programmable latency and run time
        run_op(8'h40, 0, 1);
        run_op(8'h50, 3, 4);
        run_op(8'h60, 1, 9);
        run_op(8'h70, 7, 0);
        // reset in the middle of an operation
        wrb(16'h9105, 8'h81, "R4");
        cyc(0, 0, 0, 16'h0, 8'h00, 1, 0, "R5");
        cyc(1, 0, 0, 16'h0, 8'h00, 0, 0, "R9");
        rdb(16'h9105, "R9");
        rdb(16'h9101, "R9");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired, run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule